// File: doc/BRIEF.md
# Cascade Identifier Selector for Chained Interrupt Controllers

This block lets several interrupt controllers share one interrupt line and one data bus. One device is the master and up to eight are slaves. A 3-bit cascade bus connects them. Only the master drives the bus, and each slave reads it.

When an acknowledge sequence starts, the master captures the winning request level. If that level has a slave attached, the master drives the level number on the cascade bus until the sequence ends. Each slave compares the bus value with its own programmed identifier when the first acknowledge pulse ends. Only the matching slave enables its data bus driver, and only during the pulses that carry vector bytes. If the winning level has no slave attached, the master supplies the vector bytes itself.

Two sequence shapes are supported:
- **Three-pulse mode.** The master always supplies the opening byte. The vector follows on pulses two and three.
- **Two-pulse mode.** No device drives the data bus during the first pulse. The vector follows on pulse two.

The block does not generate vectors or resolve priority. Every pin is a plain control level. Because there is no data stream, there is no valid/ready handshake and no back-pressure.

Top module: `cascade_sel`

## Requirements
- R1: After reset, `cas_oe` and `data_oe` are both low.
- R2: A master captures `win_level` on the clock edge that first sees `ack` high in an idle sequence. If `slave_mask[level]` is 1, the following happens from the next cycle until the sequence ends:
  - `cas_oe` is high.
  - `cas_out` equals the captured level.
  - Later changes of `win_level` have no effect.
- R3: A master whose captured level has `slave_mask[level]` = 0 keeps `cas_oe` low for the whole sequence.
- R4: In three-pulse mode (`call_mode` = 1), a master raises `data_oe` during the first pulse whatever the mask holds.
- R5: A master raises `data_oe` during vector pulses only when the captured level has no slave attached.
- R6: In two-pulse mode (`call_mode` = 0), no device raises `data_oe` during the first pulse.
- R7: A slave latches whether `cas_in` equals `own_id` on the edge that sees the first pulse end. On a match, it raises `data_oe` during the vector pulses (pulse index 1 and above).
- R8: A slave whose latched compare failed keeps `data_oe` low for the whole sequence.
- R9: A slave never raises `cas_oe`.
- R10: A sequence ends on the edge that sees the last pulse fall:
  - In three-pulse mode, this is the third pulse.
  - In two-pulse mode, this is the second pulse.
  
  After that edge `cas_oe` is low, and the next pulse starts a new sequence.
- R11: `data_oe` is high only while `ack` is high and was high on the previous edge. It drops in the same cycle that `ack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| call_mode | input | 1 | 1 = three-pulse sequence, 0 = two-pulse sequence |
| slave_mask | input | 8 | Bit n set = a slave hangs on level n (used by the master) |
| own_id | input | 3 | Programmed identifier (used by a slave) |
| win_level | input | 3 | Winning request level from the priority logic |
| ack | input | 1 | Acknowledge pulse, active high |
| cas_in | input | 3 | Cascade bus as seen at the pins |
| cas_out | output | 3 | Cascade value driven by the master |
| cas_oe | output | 1 | Cascade output enable |
| data_oe | output | 1 | This device drives the data bus |

## Verification
The functions that most often coincide are the master's release of the cascade bus and the next sequence's first pulse. The matching slave's latch of the bus value and the master's drive of that same bus are also tied together.

The bench provokes both cases in the following way:
- One master and two slaves (identifiers 2 and 5) are wired to a shared cascade bus.
- Sequences run back to back with only two idle cycles between them.
- `win_level` changes in the middle of a sequence.

A behavioural model predicts, every cycle, each device's enables and the master's cascade value.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int ID_W = 3;
  localparam int NLEV = 1 << ID_W;
  localparam int PH_W = 2;
  typedef enum logic [PH_W-1:0] {
    PH_LEAD = 2'd0,
    PH_VEC1 = 2'd1,
    PH_VEC2 = 2'd2
  } ack_phase_t;
endpackage

// File: rtl/ack_sequencer.sv
module ack_sequencer
  import cascade_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_mode,
  input  logic       ack,
  output logic       seq_busy,
  output ack_phase_t seq_phase,
  output logic       pulse_on,
  output logic       lead_rise,
  output logic       lead_fall,
  output logic       seq_done
);
  logic       ack_q;
  logic       rise, fall;
  ack_phase_t last_ph;

  assign rise      = ack & ~ack_q;
  assign fall      = ~ack & ack_q;
  assign last_ph   = call_mode ? PH_VEC2 : PH_VEC1;
  assign lead_rise = rise & ~seq_busy;
  assign lead_fall = fall & seq_busy & (seq_phase == PH_LEAD);
  assign seq_done  = fall & seq_busy & (seq_phase == last_ph);
  assign pulse_on  = ack & ack_q & seq_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      seq_busy  <= 1'b0;
      seq_phase <= PH_LEAD;
    end else begin
      ack_q <= ack;
      if (lead_rise) begin
        seq_busy  <= 1'b1;
        seq_phase <= PH_LEAD;
      end else if (seq_done) begin
        seq_busy  <= 1'b0;
        seq_phase <= PH_LEAD;
      end else if (fall && seq_busy) begin
        seq_phase <= ack_phase_t'(seq_phase + 2'd1);
      end
    end
  end
endmodule

// File: rtl/cascade_driver.sv
module cascade_driver
  import cascade_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic [NLEV-1:0] slave_mask,
  input  logic [ID_W-1:0] win_level,
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] cas_in,
  input  logic            seq_busy,
  input  logic            lead_rise,
  input  logic            lead_fall,
  input  logic            seq_done,
  output logic [ID_W-1:0] cas_out,
  output logic            cas_oe,
  output logic            slave_hit,
  output logic            id_match
);
  logic [ID_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      id_match <= 1'b0;
    end else begin
      if (lead_rise) lvl_q <= win_level;
      if (lead_fall)     id_match <= ~is_master & (cas_in == own_id);
      else if (seq_done) id_match <= 1'b0;
    end
  end

  assign slave_hit = slave_mask[lvl_q];
  assign cas_oe    = is_master & seq_busy & slave_hit;
  assign cas_out   = cas_oe ? lvl_q : '0;
endmodule

// File: rtl/data_drive_ctl.sv
module data_drive_ctl
  import cascade_pkg::*;
(
  input  logic       is_master,
  input  logic       call_mode,
  input  ack_phase_t seq_phase,
  input  logic       pulse_on,
  input  logic       slave_hit,
  input  logic       id_match,
  output logic       data_oe
);
  logic drive;

  always_comb begin
    if (seq_phase == PH_LEAD)
      drive = is_master & call_mode;
    else if (is_master)
      drive = ~slave_hit;
    else
      drive = id_match;
  end

  assign data_oe = pulse_on & drive;
endmodule

// File: rtl/cascade_sel.sv
module cascade_sel
  import cascade_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_master,
  input  logic            call_mode,
  input  logic [NLEV-1:0] slave_mask,
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] win_level,
  input  logic            ack,
  input  logic [ID_W-1:0] cas_in,
  output logic [ID_W-1:0] cas_out,
  output logic            cas_oe,
  output logic            data_oe
);
  logic       seq_busy, pulse_on, lead_rise, lead_fall, seq_done;
  logic       slave_hit, id_match;
  ack_phase_t seq_phase;

  ack_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .call_mode(call_mode), .ack(ack),
    .seq_busy(seq_busy), .seq_phase(seq_phase), .pulse_on(pulse_on),
    .lead_rise(lead_rise), .lead_fall(lead_fall), .seq_done(seq_done)
  );

  cascade_driver u_cas (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .slave_mask(slave_mask),
    .win_level(win_level), .own_id(own_id), .cas_in(cas_in),
    .seq_busy(seq_busy), .lead_rise(lead_rise), .lead_fall(lead_fall),
    .seq_done(seq_done), .cas_out(cas_out), .cas_oe(cas_oe),
    .slave_hit(slave_hit), .id_match(id_match)
  );

  data_drive_ctl u_drv (
    .is_master(is_master), .call_mode(call_mode), .seq_phase(seq_phase),
    .pulse_on(pulse_on), .slave_hit(slave_hit), .id_match(id_match),
    .data_oe(data_oe)
  );
endmodule

// File: rtl/cascade_sel_chk.sv
module cascade_sel_chk
  import cascade_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            is_master,
  input logic            call_mode,
  input logic            ack,
  input logic [ID_W-1:0] cas_out,
  input logic            cas_oe,
  input logic            data_oe,
  input logic            seq_busy,
  input ack_phase_t      seq_phase
);
  // R9
  slave_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !cas_oe);
  // R11
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ack);
  // R6
  ptr_lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_mode && seq_phase == PH_LEAD) |-> !data_oe);
  // R5
  master_vec_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && cas_oe && seq_phase != PH_LEAD) |-> !data_oe);
  // R2
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_oe && $past(cas_oe)) |-> $stable(cas_out));
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !cas_oe);
endmodule

bind cascade_sel cascade_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .call_mode(call_mode),
  .ack(ack), .cas_out(cas_out), .cas_oe(cas_oe), .data_oe(data_oe),
  .seq_busy(seq_busy), .seq_phase(seq_phase)
);

// File: tb/cascade_sel_tb_top.sv
module cascade_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'b0010_0100;
  localparam logic [2:0] ID_A = 3'd2;
  localparam logic [2:0] ID_B = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_mode = 1'b1;
  logic [2:0] win_level = 3'd0;
  logic       ack = 1'b0;
  logic [2:0] m_cas_out, a_cas_out, b_cas_out, bus;
  logic       m_cas_oe, a_cas_oe, b_cas_oe;
  logic       m_doe, a_doe, b_doe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus = m_cas_oe ? m_cas_out : 3'd0;

  cascade_sel dut_i (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .call_mode(call_mode),
    .slave_mask(MASK), .own_id(3'd0), .win_level(win_level), .ack(ack),
    .cas_in(3'd0), .cas_out(m_cas_out), .cas_oe(m_cas_oe), .data_oe(m_doe)
  );
  cascade_sel slv_a (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .call_mode(call_mode),
    .slave_mask(8'd0), .own_id(ID_A), .win_level(3'd0), .ack(ack),
    .cas_in(bus), .cas_out(a_cas_out), .cas_oe(a_cas_oe), .data_oe(a_doe)
  );
  cascade_sel slv_b (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .call_mode(call_mode),
    .slave_mask(8'd0), .own_id(ID_B), .win_level(3'd0), .ack(ack),
    .cas_in(bus), .cas_out(b_cas_out), .cas_oe(b_cas_oe), .data_oe(b_doe)
  );

  // behavioural reference state
  bit pa, busy;
  int np, lvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      pa = 0; busy = 0; np = 0; lvl = 0;
    end else begin
      if (ack && !pa && !busy) begin busy = 1; lvl = win_level; np = 0; end
      else if (!ack && pa && busy) begin
        if (np == (call_mode ? 2 : 1)) begin busy = 0; np = 0; end
        else np++;
      end
      pa = ack;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit att, live;
      int sent;
      string dreq;
      att  = MASK[lvl];
      live = ack && pa && busy;
      sent = att ? lvl : 0;
      chk(!busy ? "R10" : (att ? "R2" : "R3"), "master cas_oe", m_cas_oe, busy && att);
      if (busy && att) chk("R2", "master cas_out", m_cas_out, lvl);
      if (!ack) dreq = "R11";
      else if (np == 0) dreq = call_mode ? "R4" : "R6";
      else dreq = "R5";
      chk(dreq, "master data_oe", m_doe,
          live && ((np == 0) ? call_mode : !att));
      chk(np == 0 ? "R6" : (sent == ID_A ? "R7" : "R8"), "slave A data_oe",
          a_doe, live && np >= 1 && sent == ID_A);
      chk(np == 0 ? "R6" : (sent == ID_B ? "R7" : "R8"), "slave B data_oe",
          b_doe, live && np >= 1 && sent == ID_B);
      chk("R9", "slave cas_oe", a_cas_oe | b_cas_oe, 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse();
    ack = 1'b1; step(3);
    ack = 1'b0; step(2);
  endtask

  task automatic sequence_run(bit cm, int level, bit disturb);
    call_mode = cm;
    win_level = 3'(level);
    pulse();
    if (disturb) win_level = 3'(level ^ 7);
    pulse();
    if (cm) pulse();
    step(1);
  endtask

  initial begin
    step(2);
    // R1 reset state
    chk("R1", "reset cas_oe", m_cas_oe | a_cas_oe | b_cas_oe, 0);
    chk("R1", "reset data_oe", m_doe | a_doe | b_doe, 0);
    rst_n = 1'b1;
    step(2);
    sequence_run(1, 2, 0);   // slave A addressed, three-pulse
    sequence_run(1, 5, 1);   // slave B, level changes mid-sequence
    sequence_run(1, 3, 0);   // no slave: master supplies vector
    sequence_run(0, 5, 0);   // two-pulse, slave B
    sequence_run(0, 1, 0);   // two-pulse, master supplies
    sequence_run(0, 2, 1);   // two-pulse, slave A, disturbed
    call_mode = 1; win_level = 3'd5;
    pulse(); pulse(); pulse();           // back-to-back, R10 restart
    win_level = 3'd2;
    pulse(); pulse(); pulse();
    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule